// File: doc/BRIEF.md
# Banked Shared Memory Conflict Scheduler

This block takes a single shared-memory request from a group of 16 lanes and spreads it over a memory made of 16 banks. Each bank is one 4-byte word wide and can serve one word per clock. Every lane has an active bit and a word address. A lane's bank is given by the low four bits of its word address, so consecutive words fall in consecutive banks. When lanes ask for different words in the same bank, the block serves them in separate cycles. Lanes that ask for the same word are served together in one fetch, as a broadcast.

A request is accepted on a one-cycle `req_valid` pulse while the block is idle. The block then runs one serve cycle per bank round. In each round, every bank takes the word asked for by its lowest-numbered lane that has not yet been served. All unserved lanes that ask for that same word are granted in that round. The block shows the lanes granted in the round and, for each bank, the word address it fetches. It raises `done` in the final round.

The conflict degree is also reported and held until the next request. It is the largest number of distinct words that any one bank must deliver. The number of serve cycles equals the conflict degree, except that an empty request takes one cycle.

The controller has two states. In `ST_IDLE` the block waits, and `req_valid` moves it to `ST_SERVE` (the accept transition). `ST_SERVE` stays in place while any lane is still unserved after the current round (the continue transition). It returns to `ST_IDLE` in the round that serves the last lanes (the finish transition).

Top module: `bank_sched`

## Requirements
- R1: A lane's bank is bits [3:0] of its word address; `bank_addr` slice b is only enabled with a word whose low four bits equal b.
- R2: In each serve cycle, every bank that has an unserved active lane fetches the word of its lowest-numbered unserved lane. Every unserved lane requesting exactly that word is granted in that cycle.
- R3: Two lanes requesting different words in the same bank are never granted in the same cycle.
- R4: When all 16 lanes request one identical word, all are granted in a single cycle with `done` high, and `degree` reads 1.
- R5: `degree` equals the maximum over banks of the count of distinct words requested by active lanes. A word stride of 1 gives 1, a stride of 2 gives 2, a stride of 8 gives 8 and a stride of 16 gives 16. It is 0 for a request with no active lane.
- R6: `busy` lasts exactly `degree` cycles, or one cycle when `degree` is 0, and `done` is high only in the last of them.
- R7: Every active lane is granted exactly once per request, and an inactive lane is never granted, whatever its address.
- R8: A `req_valid` pulse while `busy` is high is ignored: the grant sequence and `degree` of the running request do not change.
- R9: After reset `busy`, `grant_valid`, `grant_mask`, `bank_en`, `done` and `degree` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request pulse, taken only when idle |
| req_active | input | LANES | Active bit per lane |
| req_addr | input | LANES*AW | Word address per lane, lane i at bits [i*AW +: AW] |
| busy | output | 1 | High in every serve cycle |
| grant_valid | output | 1 | Grant outputs are meaningful this cycle |
| grant_mask | output | LANES | Lanes served this cycle |
| bank_en | output | BANKS | Bank performs a fetch this cycle |
| bank_addr | output | BANKS*AW | Word fetched by each bank, bank b at bits [b*AW +: AW] |
| done | output | 1 | Last serve cycle of the request |
| degree | output | $clog2(LANES+1) | Conflict degree of the latest accepted request |

## Verification
A unit stride must finish in one round, and a stride of 2 must split into two rounds of eight lanes each. These two patterns show whether bank selection uses the low address bits. Strides of 8 and 16 push the serialization up to 8 and 16 rounds and check that the lowest unserved lane goes first. A request where every lane reads one word separates broadcast merging from conflict serialization. A request with a single active lane, placed among inactive lanes that would conflict, shows that inactive lanes are masked. Further tests use random active masks with addresses packed into a small range, which produce mixed duplicates and conflicts. An empty request and a pulse sent in the middle of a 16-round request cover the single-cycle case and the rule that a busy block ignores new requests.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } bsc_state_e;
endpackage

// File: rtl/bsc_bank_pick.sv
// One bank's round: pick the lowest unserved lane mapped here and grant
// every unserved lane that asks for the same word.
module bsc_bank_pick #(
    parameter int LANES   = 16,
    parameter int AW      = 12,
    parameter int BW      = 4,
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES*AW-1:0] addr,
    output logic                en,
    output logic [AW-1:0]       waddr,
    output logic [LANES-1:0]    gmask
);
    localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

    always_comb begin
        en    = 1'b0;
        waddr = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i] && (addr[i*AW +: BW] == MY_BANK)) begin
                en    = 1'b1;
                waddr = addr[i*AW +: AW];
            end
        end
        for (int i = 0; i < LANES; i++) begin
            gmask[i] = en && pend[i] && (addr[i*AW +: AW] == waddr);
        end
    end
endmodule

// File: rtl/bsc_degree.sv
// Conflict degree: distinct words per bank, maximum over banks.
module bsc_degree #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int AW    = 12,
    parameter int BW    = 4,
    parameter int DW    = 5
) (
    input  logic [LANES-1:0]    active,
    input  logic [LANES*AW-1:0] addr,
    output logic [DW-1:0]       deg
);
    logic [LANES-1:0] first_use;
    logic [DW-1:0]    per_bank [BANKS];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            first_use[i] = active[i];
            for (int j = 0; j < i; j++) begin
                if (active[j] && (addr[j*AW +: AW] == addr[i*AW +: AW])) begin
                    first_use[i] = 1'b0;
                end
            end
        end
        for (int b = 0; b < BANKS; b++) begin
            per_bank[b] = '0;
        end
        for (int i = 0; i < LANES; i++) begin
            if (first_use[i]) begin
                per_bank[addr[i*AW +: BW]] = per_bank[addr[i*AW +: BW]] + DW'(1);
            end
        end
        deg = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (per_bank[b] > deg) begin
                deg = per_bank[b];
            end
        end
    end
endmodule

// File: rtl/bank_sched.sv
module bank_sched
    import bsc_pkg::*;
#(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int AW    = 12,
    localparam int BW   = $clog2(BANKS),
    localparam int DW   = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    output logic                busy,
    output logic                grant_valid,
    output logic [LANES-1:0]    grant_mask,
    output logic [BANKS-1:0]    bank_en,
    output logic [BANKS*AW-1:0] bank_addr,
    output logic                done,
    output logic [DW-1:0]       degree
);
    bsc_state_e          state;
    logic [LANES-1:0]    pend;
    logic [LANES*AW-1:0] addr_q;
    logic [DW-1:0]       deg_q;
    logic [DW-1:0]       deg_calc;

    logic [BANKS-1:0]    en_v;
    logic [BANKS*AW-1:0] addr_v;
    logic [LANES-1:0]    gpart [BANKS];
    logic [LANES-1:0]    gmask_all;
    logic                last_round;

    bsc_degree #(
        .LANES(LANES), .BANKS(BANKS), .AW(AW), .BW(BW), .DW(DW)
    ) u_degree (
        .active (req_active),
        .addr   (req_addr),
        .deg    (deg_calc)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bsc_bank_pick #(
            .LANES(LANES), .AW(AW), .BW(BW), .BANK_ID(b)
        ) u_pick (
            .pend  (pend),
            .addr  (addr_q),
            .en    (en_v[b]),
            .waddr (addr_v[b*AW +: AW]),
            .gmask (gpart[b])
        );
    end

    always_comb begin
        gmask_all = '0;
        for (int b = 0; b < BANKS; b++) begin
            gmask_all = gmask_all | gpart[b];
        end
        last_round = ((pend & ~gmask_all) == '0);
    end

    // State register and request storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= '0;
            addr_q <= '0;
            deg_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        pend   <= req_active;
                        addr_q <= req_addr;
                        deg_q  <= deg_calc;
                        state  <= ST_SERVE;
                    end
                end
                ST_SERVE: begin
                    pend <= pend & ~gmask_all;
                    if (last_round) begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy        = 1'b0;
        grant_valid = 1'b0;
        grant_mask  = '0;
        bank_en     = '0;
        bank_addr   = '0;
        done        = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_SERVE: begin
                busy        = 1'b1;
                grant_valid = 1'b1;
                grant_mask  = gmask_all;
                bank_en     = en_v;
                bank_addr   = addr_v;
                done        = last_round;
            end
        endcase
    end

    assign degree = deg_q;
endmodule

// File: rtl/bsc_chk.sv
module bsc_chk #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int AW    = 12,
    localparam int BW   = $clog2(BANKS),
    localparam int DW   = $clog2(LANES + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                busy,
    input logic [LANES-1:0]    grant_mask,
    input logic [BANKS-1:0]    bank_en,
    input logic [BANKS*AW-1:0] bank_addr,
    input logic                done,
    input logic [DW-1:0]       degree
);
    logic [LANES-1:0] served;
    logic [DW:0]      cyc;
    logic [DW:0]      want_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            served <= '0;
            cyc    <= '0;
        end else if (req_valid && !busy) begin
            served <= '0;
            cyc    <= '0;
        end else if (busy) begin
            served <= served | grant_mask;
            cyc    <= cyc + 1'b1;
        end
    end

    always_comb begin
        want_len = (degree == '0) ? (DW+1)'(1) : {1'b0, degree};
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bk
        p_bank_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
            bank_en[b] |-> (bank_addr[b*AW +: BW] == BW'(b)));
    end

    p_bank_grants_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(bank_en) <= $countones(grant_mask)));

    p_no_regrant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((grant_mask & served) == '0));

    p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((cyc + 1'b1) == want_len));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(degree)));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (grant_mask == '0 && bank_en == '0 && !done));
endmodule

bind bank_sched bsc_chk #(
    .LANES(LANES), .BANKS(BANKS), .AW(AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .grant_mask (grant_mask),
    .bank_en    (bank_en),
    .bank_addr  (bank_addr),
    .done       (done),
    .degree     (degree)
);

// File: tb/sim_bank_sched.sv
module sim_bank_sched;
    localparam int CLK_P = 10;
    localparam int LN    = 16;
    localparam int AWB   = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [LN-1:0]   req_active = '0;
    logic [LN*AWB-1:0] req_addr = '0;
    logic            busy, grant_valid, done;
    logic [LN-1:0]   grant_mask;
    logic [LN-1:0]   bank_en;
    logic [LN*AWB-1:0] bank_addr;
    logic [4:0]      degree;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_tag = "R9";

    logic [LN-1:0] exp_mask_q[$];
    bit            exp_done_q[$];
    int            m_addr[LN];
    logic [LN-1:0] m_act;

    bank_sched u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_active(req_active), .req_addr(req_addr),
        .busy(busy), .grant_valid(grant_valid), .grant_mask(grant_mask),
        .bank_en(bank_en), .bank_addr(bank_addr), .done(done),
        .degree(degree)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each serve cycle against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && busy && !finished) begin
                if (exp_mask_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL %s R6 unexpected busy cycle actual=1 expected=0", cur_tag);
                end else begin
                    logic [LN-1:0] em;
                    bit ed;
                    em = exp_mask_q.pop_front();
                    ed = exp_done_q.pop_front();
                    check({cur_tag, " grant"}, int'(grant_mask), int'(em));
                    check({cur_tag, " R6 done"}, int'(done), int'(ed));
                end
            end
        end
    end

    function automatic int model_degree();
        int best = 0;
        for (int b = 0; b < LN; b++) begin
            int cnt = 0;
            for (int i = 0; i < LN; i++) begin
                if (m_act[i] && (m_addr[i] % 16) == b) begin
                    bit dup = 0;
                    for (int j = 0; j < i; j++)
                        if (m_act[j] && m_addr[j] == m_addr[i]) dup = 1;
                    if (!dup) cnt++;
                end
            end
            if (cnt > best) best = cnt;
        end
        return best;
    endfunction

    // Driver: push expected rounds, then issue the request
    task automatic run_req(string tag, int exp_deg, bit poke);
        logic [LN-1:0] pending = m_act;
        int md = model_degree();
        cur_tag = tag;
        if (exp_deg >= 0) check({tag, " R5 model"}, md, exp_deg);
        do begin
            logic [LN-1:0] g = '0;
            for (int b = 0; b < LN; b++) begin
                int low = -1;
                for (int i = 0; i < LN; i++)
                    if (low < 0 && pending[i] && (m_addr[i] % 16) == b) low = i;
                if (low >= 0)
                    for (int i = 0; i < LN; i++)
                        if (pending[i] && m_addr[i] == m_addr[low]) g[i] = 1'b1;
            end
            pending = pending & ~g;
            exp_mask_q.push_back(g);
            exp_done_q.push_back(pending == '0);
        end while (pending != '0);
        @(negedge clk);
        req_valid  = 1'b1;
        req_active = m_act;
        for (int i = 0; i < LN; i++) req_addr[i*AWB +: AWB] = AWB'(m_addr[i]);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R8: new request while busy must be ignored
            @(negedge clk);
            req_valid  = 1'b1;
            req_active = '1;
            req_addr   = '0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (exp_mask_q.size() != 0 || busy) @(negedge clk);
        check({tag, " R5 degree"}, int'(degree), md);
        check({tag, " R8 idle after"}, int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 busy", int'(busy), 0);
        check("R9 grant", int'(grant_mask), 0);
        check("R9 done", int'(done), 0);
        check("R9 degree", int'(degree), 0);
        check("R9 bank_en", int'(bank_en), 0);
        check("R9 grant_valid", int'(grant_valid), 0);

        m_act = '1;
        for (int i = 0; i < LN; i++) m_addr[i] = 100 + i;
        run_req("R5 R1 stride1", 1, 0);

        for (int i = 0; i < LN; i++) m_addr[i] = 2 * i;
        run_req("R5 R3 stride2", 2, 0);

        for (int i = 0; i < LN; i++) m_addr[i] = 8 * i + 3;
        run_req("R5 R2 stride8", 8, 0);

        for (int i = 0; i < LN; i++) m_addr[i] = 37;
        run_req("R4 broadcast", 1, 0);

        m_act = '0;
        run_req("R6 empty", 0, 0);

        m_act = 16'h0001;
        for (int i = 0; i < LN; i++) m_addr[i] = 16 * i;
        run_req("R7 inactive", 1, 0);

        m_act = '1;
        run_req("R8 stride16 poke", 16, 1);

        for (int k = 0; k < 12; k++) begin
            m_act = LN'($urandom);
            for (int i = 0; i < LN; i++) m_addr[i] = int'($urandom % 40);
            run_req("R2 R3 R7 random", -1, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule